// File: doc/BRIEF.md
# SPI Target with Byte FIFOs and Receive Timeout

This block is a memory-mapped SPI target. An external controller owns the serial clock and the select line. The block moves one byte per frame slot in each direction: bytes shifted in on the data-in pin go into a small receive queue, and bytes the host has queued are shifted out on the data-out pin. The bit order is selectable, and all four clock polarity and phase combinations are supported. The serial pins are brought into the system clock domain through two-stage synchronizers. The system clock must therefore run at least four times faster than the serial clock.

Software uses five word registers. The control register sets the mode, the enables and the timeout window. The status register shows the occupancy of both queues, a sticky overrun flag, the current select level and two interrupt sources. A write-one-to-clear register acknowledges the flags and flushes either queue. The transmit data register accepts a byte, and reading the receive data register removes one byte. A programmable inter-byte timeout flags a receive stream that stops while unread data is still held. Separate request lines can hand either data register to a DMA engine.

Top module: `spi_target_fifo`

## Requirements
- R1: After reset the control register reads 0x00000008, with only receive enable set. The status register reads 0x00000181 while the select pin is high. Status bit 7 follows the select pin level.
- R2: Control bits 0 (LSB-first), 1 (polarity) and 2 (phase) take a written value only if the enable bit 7 was 0 before the write. Otherwise they keep their old value, while the other fields still update.
- R3: In MSB-first order, in each of the four modes (polarity in bit 1, phase in bit 2), a frame delivers the received byte to the receive data register (offset 0x10). The same frame shifts out the byte written to transmit data (offset 0x0C).
- R4: With control bit 0 set, both directions transfer the least significant bit first.
- R5: A completed byte enters the receive queue and sets the receive interrupt status only when both enable (bit 7) and receive enable (bit 3) are 1.
- R6: The receive queue holds 4 bytes and returns them in arrival order. Status bit 0 means empty, bit 1 means full, and bits [4:2] give the count. Reading receive data while the queue is empty returns 0.
- R7: A byte that completes while the receive queue is full is dropped, and the stored bytes are kept. This sets the sticky overrun flag (status bit 6), which clears only when bit 0 of the clear register (offset 0x08) is written with 1.
- R8: Each received byte sets status bit 16, which stays set until clear bit 3 is written. The interrupt output is high when bit 16 and enable bit 4 are both set, or when bit 17 and enable bit 17 are both set.
- R9: If the transmit queue is empty when a byte starts, the block shifts out 0xFF.
- R10: The transmit queue holds 4 bytes. Writes while it is full are ignored. Status bit 8 means empty, bit 9 means full, and bits [12:10] give the count.
- R11: Clear bit 1 empties the transmit queue and clear bit 2 empties the receive queue. Flushed bytes are never delivered.
- R12: With timeout enable (bit 16) set and a non-zero window in bits [15:8], status bit 17 sets once the window, counted in bit times, passes with select low, unread receive data and no new sampled bit. The bit time is the interval between the last two sampling edges. Clear bit 4 clears status bit 17. No timeout occurs while select is high.
- R13: With control bit 5 set, the transmit request is high while the transmit queue is not full. With control bit 6 set, the receive request is high while the receive queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_cs_n | input | 1 | Select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Transmit data request |
| dma_rx_req | output | 1 | Receive data request |

## Verification
If the bit counter or shift registers are corrupted, the next frame shows a misaligned or bit-reversed byte, both at the data-out pin and in the receive data register, within eight serial clocks. If a queue pointer or count is wrong, the status fields and the read order of received bytes disagree after the next push or pop. A wrong flag or timer state shows up on the interrupt output and in status bits 6, 16 and 17 within a few register accesses. For the timeout, that is within one window of the last sampled bit.

// File: rtl/spit_pkg.sv
package spit_pkg;
   localparam int REG_AW = 5;
   localparam logic [REG_AW-1:0] ADR_CTRL = 5'h00;
   localparam logic [REG_AW-1:0] ADR_STAT = 5'h04;
   localparam logic [REG_AW-1:0] ADR_CLR  = 5'h08;
   localparam logic [REG_AW-1:0] ADR_TXD  = 5'h0C;
   localparam logic [REG_AW-1:0] ADR_RXD  = 5'h10;

   // control word, bit 17 down to bit 0
   typedef struct packed {
      logic       otint_en;
      logic       ot_en;
      logic [7:0] ot_win;
      logic       en;
      logic       rx_dma;
      logic       tx_dma;
      logic       rxint_en;
      logic       rx_en;
      logic       cpha;
      logic       cpol;
      logic       lsb;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = ctrl_t'(18'h00008);

   // write-one-to-clear bit positions
   localparam int CLR_OVR = 0;
   localparam int CLR_TXQ = 1;
   localparam int CLR_RXQ = 2;
   localparam int CLR_RXI = 3;
   localparam int CLR_OTI = 4;
endpackage

// File: rtl/spit_sync.sv
module spit_sync #(
   parameter int          N       = 3,
   parameter int          STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spit_sync needs at least two stages");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end
endmodule

// File: rtl/spit_fifo.sv
module spit_fifo #(
   parameter  int W     = 8,
   parameter  int DEPTH = 4,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("spit_fifo depth must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_n, rp_n;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rp];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_n = wp + 1'b1;
      assign rp_n = rp + 1'b1;
   end else begin : g_wrap
      assign wp_n = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_n = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (do_push) begin
            mem[wp] <= din;
            wp      <= wp_n;
         end
         if (do_pop) rp <= rp_n;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop && !clr) |=> full) else $error("queue lost its full state");  // R6
   AST_FIFO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty) else $error("flush did not empty the queue");  // R11
endmodule

// File: rtl/spit_engine.sv
module spit_engine #(
   parameter  int BW = 8,
   localparam int CW = $clog2(BW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          cpol,
   input  logic          cpha,
   input  logic          lsb,
   input  logic          sck_s,
   input  logic          mosi_s,
   input  logic [BW-1:0] tx_byte,
   input  logic          tx_avail,
   output logic          tx_pop,
   output logic          miso,
   output logic          smp,
   output logic          rx_valid,
   output logic [BW-1:0] rx_byte
);
   if (BW < 2) begin : g_bad_width
      $error("spit_engine needs at least two bits per word");
   end

   logic          k, pk, active_q;
   logic          lead, trail, shf, start, last, load, shift;
   logic [CW-1:0] cnt;
   logic [BW-1:0] tx_sh, rx_sh, rx_nxt;

   assign k      = sck_s ^ cpol;
   assign lead   = active & k & ~pk;
   assign trail  = active & ~k & pk;
   assign smp    = cpha ? trail : lead;
   assign shf    = cpha ? lead : trail;
   assign start  = active & ~active_q;
   assign last   = (cnt == CW'(BW - 1));
   assign load   = cpha ? (shf & (cnt == '0)) : (start | (smp & last));
   assign shift  = shf & (cnt != '0);
   assign tx_pop = load & tx_avail;
   assign miso   = lsb ? tx_sh[0] : tx_sh[BW-1];
   assign rx_nxt = lsb ? {mosi_s, rx_sh[BW-1:1]} : {rx_sh[BW-2:0], mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pk       <= 1'b0;
         active_q <= 1'b0;
         cnt      <= '0;
         tx_sh    <= '1;
         rx_sh    <= '0;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
      end else begin
         pk       <= k;
         active_q <= active;
         rx_valid <= smp & last;
         if (!active)  cnt <= '0;
         else if (smp) cnt <= last ? '0 : cnt + 1'b1;
         if (smp) rx_sh <= rx_nxt;
         if (smp && last) rx_byte <= rx_nxt;
         if (load)       tx_sh <= tx_avail ? tx_byte : '1;
         else if (shift) tx_sh <= lsb ? {1'b1, tx_sh[BW-1:1]} : {tx_sh[BW-2:0], 1'b1};
      end
   end

   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0)) else $error("bit count kept while idle");  // R3
   AST_ONE_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid) else $error("byte strobe longer than one cycle");  // R5
endmodule

// File: rtl/spit_timeout.sv
module spit_timeout #(
   parameter int WIN_W = 8,
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp,
   input  logic             run,
   input  logic [WIN_W-1:0] win,
   output logic             expire
);
   if (CNT_W < 4) begin : g_bad_cnt
      $error("spit_timeout period counter too narrow");
   end

   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [CNT_W-1:0] per, blen, sub;
   logic [WIN_W-1:0] units;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per    <= '0;
         blen   <= CMAX;
         sub    <= '0;
         units  <= '0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (smp) begin
            per  <= '0;
            blen <= (per == CMAX) ? CMAX : per + 1'b1;
         end else if (per != CMAX) begin
            per <= per + 1'b1;
         end
         if (smp || !run) begin
            sub   <= '0;
            units <= '0;
         end else if (units != win) begin
            if (sub >= blen - 1'b1) begin
               sub   <= '0;
               units <= units + 1'b1;
               if (units == win - 1'b1) expire <= 1'b1;
            end else begin
               sub <= sub + 1'b1;
            end
         end
      end
   end

   AST_OT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire) else $error("timeout fired twice in a row");  // R12
endmodule

// File: rtl/spi_target_fifo.sv
module spi_target_fifo
   import spit_pkg::*;
#(
   parameter  int DEPTH  = 4,
   parameter  int TCNT_W = 12,
   localparam int BW     = 8,
   localparam int QCW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              irq,
   output logic              dma_tx_req,
   output logic              dma_rx_req
);
   if (DEPTH > 7) begin : g_bad_depth
      $error("queue count must fit the 3-bit status fields");
   end

   ctrl_t          ctrl_q, ctrl_w;
   logic           sck_s, cs_s, mosi_s;
   logic           wr_ctrl, wr_clr, wr_txd, rd_rxd;
   logic           active, tx_pop, smp, rx_valid, rx_push, expire;
   logic [BW-1:0]  rx_byte, txq_dout, rxq_dout;
   logic [QCW-1:0] txq_cnt, rxq_cnt;
   logic           txq_full, txq_empty, rxq_full, rxq_empty;
   logic           ovr_q, rxi_q, oti_q;
   logic [31:0]    stat_w;
   logic           unused_bits;

   assign unused_bits = ^bus_wdata[31:18];

   spit_sync #(.N(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_mosi, spi_cs_n, spi_sck}),
      .q({mosi_s, cs_s, sck_s})
   );

   assign wr_ctrl = bus_en & bus_we & (bus_addr == ADR_CTRL);
   assign wr_clr  = bus_en & bus_we & (bus_addr == ADR_CLR);
   assign wr_txd  = bus_en & bus_we & (bus_addr == ADR_TXD);
   assign rd_rxd  = bus_en & ~bus_we & (bus_addr == ADR_RXD);

   always_comb begin
      ctrl_w = ctrl_t'(bus_wdata[17:0]);
      if (ctrl_q.en) begin
         ctrl_w.lsb  = ctrl_q.lsb;
         ctrl_w.cpol = ctrl_q.cpol;
         ctrl_w.cpha = ctrl_q.cpha;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= CTRL_RST;
      else if (wr_ctrl) ctrl_q <= ctrl_w;
   end

   assign active = ctrl_q.en & ~cs_s;

   spit_engine #(.BW(BW)) u_engine (
      .clk(clk), .rst_n(rst_n), .active(active),
      .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .lsb(ctrl_q.lsb),
      .sck_s(sck_s), .mosi_s(mosi_s),
      .tx_byte(txq_dout), .tx_avail(~txq_empty), .tx_pop(tx_pop),
      .miso(spi_miso), .smp(smp), .rx_valid(rx_valid), .rx_byte(rx_byte)
   );

   assign rx_push = rx_valid & ctrl_q.en & ctrl_q.rx_en;

   spit_fifo #(.W(BW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(wr_clr & bus_wdata[CLR_TXQ]),
      .push(wr_txd), .pop(tx_pop), .din(bus_wdata[BW-1:0]),
      .dout(txq_dout), .count(txq_cnt), .full(txq_full), .empty(txq_empty)
   );

   spit_fifo #(.W(BW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(wr_clr & bus_wdata[CLR_RXQ]),
      .push(rx_push), .pop(rd_rxd), .din(rx_byte),
      .dout(rxq_dout), .count(rxq_cnt), .full(rxq_full), .empty(rxq_empty)
   );

   spit_timeout #(.WIN_W(8), .CNT_W(TCNT_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .smp(smp),
      .run(ctrl_q.en & ctrl_q.ot_en & ~cs_s & ~rxq_empty),
      .win(ctrl_q.ot_win), .expire(expire)
   );

   // flags: a new event in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         rxi_q <= 1'b0;
         oti_q <= 1'b0;
      end else begin
         if (rx_push && rxq_full)               ovr_q <= 1'b1;
         else if (wr_clr && bus_wdata[CLR_OVR]) ovr_q <= 1'b0;
         if (rx_push)                           rxi_q <= 1'b1;
         else if (wr_clr && bus_wdata[CLR_RXI]) rxi_q <= 1'b0;
         if (expire)                            oti_q <= 1'b1;
         else if (wr_clr && bus_wdata[CLR_OTI]) oti_q <= 1'b0;
      end
   end

   assign stat_w = {14'b0, oti_q, rxi_q, 3'b0, 3'(txq_cnt), txq_full, txq_empty,
                    cs_s, ovr_q, 1'b0, 3'(rxq_cnt), rxq_full, rxq_empty};

   always_comb begin
      case (bus_addr)
         ADR_CTRL: bus_rdata = {14'b0, ctrl_q};
         ADR_STAT: bus_rdata = stat_w;
         ADR_RXD:  bus_rdata = rxq_empty ? 32'h0 : {{(32-BW){1'b0}}, rxq_dout};
         default:  bus_rdata = 32'h0;
      endcase
   end

   assign irq        = (rxi_q & ctrl_q.rxint_en) | (oti_q & ctrl_q.otint_en);
   assign dma_tx_req = ctrl_q.tx_dma & ~txq_full;
   assign dma_rx_req = ctrl_q.rx_dma & ~rxq_empty;

   AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.en |=> $stable({ctrl_q.lsb, ctrl_q.cpol, ctrl_q.cpha})) else $error("mode changed while enabled");  // R2
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !(wr_clr && bus_wdata[CLR_OVR])) |=> ovr_q) else $error("overrun flag dropped");  // R7
   AST_RXI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rxi_q && !(wr_clr && bus_wdata[CLR_RXI])) |=> rxi_q) else $error("receive status dropped");  // R8
   AST_NO_RX_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.rx_en && !rd_rxd && !(wr_clr && bus_wdata[CLR_RXQ]) && !wr_ctrl) |=> $stable(rxq_cnt)) else $error("byte stored while receive off");  // R5
endmodule

// File: tb/sim_spi_target_fifo.sv
`timescale 1ns/1ps
module sim_spi_target_fifo;
   localparam int H = 5;
   localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_CLR = 5'h08, A_TXD = 5'h0C, A_RXD = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso, irq, dma_tx_req, dma_rx_req;
   int          n_chk = 0, n_bad = 0;
   bit          b_cpol = 0, b_cpha = 0, b_lsb = 0;

   always #10 clk = ~clk;

   spi_target_fifo u0 (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
      .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] st(int rc, bit ov, bit csb, int tc, bit ri, bit oi);
      return 32'(rc == 0) | (32'(rc == 4) << 1) | (32'(rc) << 2) | (32'(ov) << 6) | (32'(csb) << 7)
           | (32'(tc == 0) << 8) | (32'(tc == 4) << 9) | (32'(tc) << 10) | (32'(ri) << 16) | (32'(oi) << 17);
   endfunction

   task automatic bw(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_en = 0; bus_we = 0;
   endtask

   task automatic br(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
      #5 d = bus_rdata;
      @(negedge clk); bus_en = 0;
   endtask

   task automatic hwait();
      repeat (H) @(negedge clk);
   endtask

   task automatic spi_begin();
      @(negedge clk); sck = b_cpol; cs_n = 0; hwait();
   endtask

   task automatic spi_end();
      hwait(); cs_n = 1; hwait(); hwait();
   endtask

   task automatic spi_byte(input logic [7:0] m, output logic [7:0] s);
      logic [7:0] r = '0;
      for (int i = 0; i < 8; i++) begin
         int idx = b_lsb ? i : 7 - i;
         if (!b_cpha) begin
            mosi = m[idx]; hwait(); r[idx] = miso; sck = ~sck; hwait(); sck = ~sck;
         end else begin
            sck = ~sck; mosi = m[idx]; hwait(); r[idx] = miso; sck = ~sck; hwait();
         end
      end
      s = r;
   endtask

   task automatic xfer1(input logic [7:0] m, output logic [7:0] s);
      spi_begin(); spi_byte(m, s); spi_end();
   endtask

   task automatic set_mode(bit cp, bit ph, bit lf, logic [31:0] extra);
      logic [31:0] m = 32'(lf) | (32'(cp) << 1) | (32'(ph) << 2);
      bw(A_CTRL, m | extra);
      b_cpol = cp; b_cpha = ph; b_lsb = lf;
      @(negedge clk); sck = cp; hwait();
      bw(A_CTRL, m | extra | 32'h80);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      br(A_CTRL, d); check("R1 ctrl reset", d, 32'h8);
      br(A_STAT, d); check("R1 status reset", d, 32'h181);
   endtask

   task automatic t_modes();
      logic [31:0] d; logic [7:0] s;
      for (int m = 0; m < 4; m++) begin
         set_mode(m[0], m[1], 0, 32'h08);
         bw(A_TXD, 32'(8'hA5 ^ 8'(m * 17)));
         xfer1(8'h3C + 8'(m), s);
         check("R3 tx byte in mode", 32'(s), 32'(8'hA5 ^ 8'(m * 17)));
         br(A_RXD, d); check("R3 rx byte in mode", d, 32'(8'h3C + 8'(m)));
         bw(A_CLR, 32'h8);
      end
      set_mode(1, 0, 1, 32'h08);
      bw(A_TXD, 32'h1E);
      xfer1(8'hC1, s);
      check("R4 lsb-first tx", 32'(s), 32'h1E);
      br(A_RXD, d); check("R4 lsb-first rx", d, 32'hC1);
      bw(A_CLR, 32'h8);
   endtask

   task automatic t_lock();
      logic [31:0] d;
      bw(A_CTRL, 32'h8C);
      br(A_CTRL, d); check("R2 mode held while enabled", d, 32'h8B);
      bw(A_CTRL, 32'h0C);
      br(A_CTRL, d); check("R2 disabling write keeps mode", d, 32'h0B);
      bw(A_CTRL, 32'h0C);
      br(A_CTRL, d); check("R2 mode written while disabled", d, 32'h0C);
   endtask

   task automatic t_idle_ff();
      logic [31:0] d; logic [7:0] s;
      set_mode(0, 0, 0, 32'h08);
      xfer1(8'h5A, s);
      check("R9 empty queue sends FF", 32'(s), 32'hFF);
      br(A_RXD, d); check("R3 rx with empty tx", d, 32'h5A);
      bw(A_CLR, 32'h8);
   endtask

   task automatic t_rx_queue();
      logic [31:0] d; logic [7:0] s;
      set_mode(0, 1, 0, 32'h18);
      spi_begin();
      for (int i = 1; i <= 5; i++) spi_byte(8'(i * 17), s);
      spi_end();
      br(A_STAT, d); check("R7 full queue and overrun", d, st(4, 1, 1, 0, 1, 0));
      check("R8 irq from receive", 32'(irq), 32'h1);
      for (int i = 1; i <= 4; i++) begin
         br(A_RXD, d); check("R6 read order", d, 32'(8'(i * 17)));
      end
      br(A_RXD, d); check("R6 empty read returns 0", d, 32'h0);
      br(A_STAT, d); check("R7 overrun stays after reads", d, st(0, 1, 1, 0, 1, 0));
      bw(A_CLR, 32'h1);
      br(A_STAT, d); check("R7 overrun cleared", d, st(0, 0, 1, 0, 1, 0));
      bw(A_CLR, 32'h8);
      br(A_STAT, d); check("R8 receive status cleared", d, st(0, 0, 1, 0, 0, 0));
      check("R8 irq low after clear", 32'(irq), 32'h0);
   endtask

   task automatic t_rx_off();
      logic [31:0] d; logic [7:0] s;
      set_mode(0, 0, 0, 32'h10);
      xfer1(8'h77, s);
      br(A_STAT, d); check("R5 no byte while receive off", d, st(0, 0, 1, 0, 0, 0));
      check("R5 irq stays low", 32'(irq), 32'h0);
   endtask

   task automatic t_tx_queue();
      logic [31:0] d; logic [7:0] s;
      set_mode(0, 0, 0, 32'h08);
      for (int i = 0; i < 5; i++) bw(A_TXD, 32'hA1 + 32'(i));
      br(A_STAT, d); check("R10 tx full, extra write ignored", d, st(0, 0, 1, 4, 0, 0));
      spi_begin();
      for (int i = 0; i < 5; i++) begin
         spi_byte(8'h00, s);
         check("R10 tx order then FF", 32'(s), (i < 4) ? 32'hA1 + 32'(i) : 32'hFF);
      end
      spi_end();
      bw(A_CLR, 32'h0D);
      br(A_STAT, d); check("R11 rx flush", d, st(0, 0, 1, 0, 0, 0));
   endtask

   task automatic t_flush();
      logic [31:0] d; logic [7:0] s;
      for (int i = 0; i < 3; i++) bw(A_TXD, 32'h60 + 32'(i));
      br(A_STAT, d); check("R10 tx count 3", d, st(0, 0, 1, 3, 0, 0));
      bw(A_CLR, 32'h2);
      br(A_STAT, d); check("R11 tx flush", d, st(0, 0, 1, 0, 0, 0));
      xfer1(8'h12, s); check("R11 flushed tx not sent", 32'(s), 32'hFF);
      xfer1(8'h34, s);
      br(A_STAT, d); check("R6 rx count 2", d, st(2, 0, 1, 0, 1, 0));
      bw(A_CLR, 32'h4);
      br(A_RXD, d); check("R11 flushed rx not returned", d, 32'h0);
      bw(A_CLR, 32'h8);
   endtask

   task automatic t_timeout();
      logic [31:0] d; logic [7:0] s;
      set_mode(0, 0, 0, 32'h30608);
      spi_begin();
      spi_byte(8'h99, s);
      repeat (25) @(negedge clk);
      br(A_STAT, d); check("R12 no timeout inside window", d & 32'h20080, 32'h0);
      repeat (50) @(negedge clk);
      br(A_STAT, d); check("R12 timeout after window", d & 32'h20080, 32'h20000);
      check("R8 irq from timeout", 32'(irq), 32'h1);
      spi_end();
      bw(A_CLR, 32'h1C);
      br(A_STAT, d); check("R12 timeout cleared", d, st(0, 0, 1, 0, 0, 0));
      check("R12 irq low after clear", 32'(irq), 32'h0);
      xfer1(8'h42, s);
      repeat (100) @(negedge clk);
      br(A_STAT, d); check("R12 no timeout with select high", d & 32'h20000, 32'h0);
      bw(A_CLR, 32'h1C);
   endtask

   task automatic t_dma();
      logic [31:0] d; logic [7:0] s;
      set_mode(0, 0, 0, 32'h68);
      #1; check("R13 tx request when not full", 32'(dma_tx_req), 32'h1);
      check("R13 no rx request when empty", 32'(dma_rx_req), 32'h0);
      for (int i = 0; i < 4; i++) bw(A_TXD, 32'h10 + 32'(i));
      check("R13 tx request drops when full", 32'(dma_tx_req), 32'h0);
      xfer1(8'h81, s);
      check("R13 tx request after pop", 32'(dma_tx_req), 32'h1);
      check("R13 rx request with data", 32'(dma_rx_req), 32'h1);
      br(A_RXD, d); check("R13 rx data via request", d, 32'h81);
      check("R13 rx request drops", 32'(dma_rx_req), 32'h0);
      bw(A_CLR, 32'h1F);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      t_reset();
      t_modes();
      t_lock();
      t_idle_ff();
      t_rx_queue();
      t_rx_off();
      t_tx_queue();
      t_flush();
      t_timeout();
      t_dma();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule